// File: doc/BRIEF.md
# Stereo Serial Sample Transmitter (Clock Master)

This block turns a pair of 18-bit two's-complement samples into a serial stream and produces every timing signal itself from the master clock. Those signals are a word clock, a bit clock and a framing strobe. Each frame carries the left sample while the word clock is high and the right sample while it is low. A 3-bit format code picks one of five layouts:

- 16-bit or 18-bit words.
- Most or least significant bit first.
- 64 or 32 bit clocks per frame.
- A framing strobe that is either a level around the word or a one-slot pulse before it.

A clock-ratio input chooses a frame of 256 or 384 master-clock cycles.

A slot is one bit-clock period. It begins at the falling edge of the bit clock. Slots are numbered from 0 inside each channel half. In 16-bit layouts the word sent is sample bits 17 down to 2. The lowest two bits are truncated.

Samples enter through a valid/ready port. `in_ready` is high for exactly one master-clock cycle per frame, in the last cycle before the frame begins. The block never waits for the producer. If `in_valid` is low in that cycle, the frame carries zero words, so there is no back-pressure on the frame timing. The format code and clock ratio are taken in the same cycle and hold for the whole frame. Outputs are registered. Slot 0 of a frame reaches the pins on the second clock edge after the `in_ready` cycle.

Top module: `stereo_ser_tx`

## Requirements
- R1: After reset, with `run` low, all four serial outputs and `in_ready` are low.
- R2: The word clock has a period of 256 master clocks when `cmode`=0 and 384 when `cmode`=1. It is high for the first half of the frame (left word) and low for the second half (right word).
- R3: For codes 011, 100 and 101 there are 64 slots per frame, each of 4 (`cmode`=0) or 6 (`cmode`=1) master clocks. For codes 110 and 111 there are 32 slots, each of 8 or 12 master clocks. The bit clock is low in the first half of each slot and high in the second half.
- R4: While running, the word clock, framing strobe and data change only in the cycle in which the bit clock falls.
- R5: Code 011 sends bits 17..2 of each sample, highest first, in slots 1 to 16 of its half. The strobe is high for exactly those slots.
- R6: Code 100 sends all 18 bits, highest first, in slots 1 to 18. The strobe is a one-slot pulse in slot 0.
- R7: Code 101 sends all 18 bits, lowest first, in slots 14 to 31, so the last bit ends at the word-clock edge. The strobe pulses in slot 13.
- R8: Codes 110 and 111 send bits 17..2 in slots 0 to 15 of their half, highest first for 110 and lowest first for 111. The strobe pulses in slot 15 of each half, the slot just before the next word.
- R9: The data line is low in every slot that carries no data bit.
- R10: `in_ready` is high in the first running cycle and in the last cycle of every frame. A pair offered with `in_valid` high is sent in the next frame, and zero words are sent when `in_valid` is low.
- R11: A change of `mode` (between codes 011 to 111) or of `cmode` during a frame takes effect only from the next frame. A change made in the `in_ready` cycle applies to the next frame.
- R12: With `run` low or `mode` in 000..010, all outputs are low from the next cycle and `in_ready` stays low. Running again starts with a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables the transmitter |
| mode | input | 3 | Format code (011..111 active, others idle) |
| cmode | input | 1 | Frame length select: 0 gives 256, 1 gives 384 master clocks |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair taken this cycle (frame start) |
| left_smp | input | 18 | Left sample, two's complement |
| right_smp | input | 18 | Right sample, two's complement |
| sclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Word clock, high for the left half |
| fsync_o | output | 1 | Framing strobe |
| dout_o | output | 1 | Serial data |

## Verification
The riskiest coincidence is a new format code arriving in the same master-clock cycle in which the frame wraps and a new sample pair is taken. In that cycle the old layout's last slot must still be finished while the new layout is latched. The bench provokes this by waiting for its own prediction of `in_ready` and then changing `mode` and `cmode` before that clock edge. It also changes the code in the middle of a frame, and it drops `run` part-way through a frame. Every cycle, each output is judged against an arithmetic model that recomputes slot, phase and bit index from the frame position and the format in force for that frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int SMP_W        = 18;
  localparam int SHORT_W      = 16;
  localparam int NUM_CH       = 2;
  localparam int WIDE_SLOTS   = 64;
  localparam int NARROW_SLOTS = 32;
  localparam int FRAME_LO     = 256;
  localparam int FRAME_HI     = 384;
  localparam int SLOT_IDX_W   = $clog2(WIDE_SLOTS);
  localparam int HALF_W       = $clog2(FRAME_HI / NARROW_SLOTS / 2 + 1);
  localparam int PH_W         = HALF_W + 1;
  localparam int WLEN_W       = $clog2(SMP_W + 1);
  localparam int IDX_W        = $clog2(SMP_W);

  typedef enum logic [2:0] {
    FMT_IDLE0   = 3'b000,
    FMT_IDLE1   = 3'b001,
    FMT_IDLE2   = 3'b010,
    FMT_BOUND16 = 3'b011,
    FMT_MSB18   = 3'b100,
    FMT_LSB18   = 3'b101,
    FMT_MSB16N  = 3'b110,
    FMT_LSB16N  = 3'b111
  } fmt_code_e;

  typedef struct packed {
    logic                  narrow;
    logic                  msb_first;
    logic                  fs_level;
    logic [WLEN_W-1:0]     wlen;
    logic [SLOT_IDX_W-1:0] first_slot;
    logic [SLOT_IDX_W-1:0] mark_slot;
    logic [HALF_W-1:0]     half_ph;
  } fmt_t;

  function automatic logic is_active_code(input logic [2:0] m);
    return m >= 3'(FMT_BOUND16);
  endfunction

  function automatic fmt_t decode_fmt(input logic [2:0] m, input logic cm);
    fmt_t f;
    f = '0;
    case (fmt_code_e'(m))
      FMT_BOUND16: begin
        f.wlen = WLEN_W'(SHORT_W);     f.first_slot = SLOT_IDX_W'(1);
        f.msb_first = 1'b1;            f.fs_level = 1'b1;
      end
      FMT_MSB18: begin
        f.wlen = WLEN_W'(SMP_W);       f.first_slot = SLOT_IDX_W'(1);
        f.msb_first = 1'b1;            f.mark_slot = '0;
      end
      FMT_LSB18: begin
        f.wlen = WLEN_W'(SMP_W);
        f.first_slot = SLOT_IDX_W'(WIDE_SLOTS / 2 - SMP_W);
        f.mark_slot  = SLOT_IDX_W'(WIDE_SLOTS / 2 - SMP_W - 1);
      end
      FMT_MSB16N, FMT_LSB16N: begin
        f.narrow = 1'b1;               f.wlen = WLEN_W'(SHORT_W);
        f.msb_first = ~m[0];           f.first_slot = '0;
        f.mark_slot = SLOT_IDX_W'(NARROW_SLOTS / 2 - 1);
      end
      default: f = '0;
    endcase
    if (f.narrow)
      f.half_ph = cm ? HALF_W'(FRAME_HI / NARROW_SLOTS / 2) : HALF_W'(FRAME_LO / NARROW_SLOTS / 2);
    else
      f.half_ph = cm ? HALF_W'(FRAME_HI / WIDE_SLOTS / 2) : HALF_W'(FRAME_LO / WIDE_SLOTS / 2);
    return f;
  endfunction
endpackage

// File: rtl/sertx_frame_timer.sv
module sertx_frame_timer
  import sertx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  live,
  input  fmt_t                  fmt_in,
  output fmt_t                  fmt_q,
  output logic [PH_W-1:0]       ph,
  output logic [SLOT_IDX_W-1:0] slot,
  output logic                  idle,
  output logic                  start
);
  localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);

  logic [PH_W-1:0]       ph_last;
  logic [SLOT_IDX_W-1:0] slot_last;
  logic                  frame_end;

  assign ph_last   = {fmt_q.half_ph, 1'b0} - PH_ONE;
  assign slot_last = fmt_q.narrow ? SLOT_IDX_W'(NARROW_SLOTS - 1) : SLOT_IDX_W'(WIDE_SLOTS - 1);
  assign frame_end = (ph == ph_last) && (slot == slot_last);
  assign start     = live && (idle || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle  <= 1'b1;
      ph    <= '0;
      slot  <= '0;
      fmt_q <= '0;
    end else if (!live) begin
      idle  <= 1'b1;
      ph    <= '0;
      slot  <= '0;
    end else if (start) begin
      idle  <= 1'b0;
      ph    <= '0;
      slot  <= '0;
      fmt_q <= fmt_in;
    end else if (ph == ph_last) begin
      ph    <= '0;
      slot  <= slot + SLOT_IDX_W'(1);
    end else begin
      ph    <= ph + PH_ONE;
    end
  end
endmodule

// File: rtl/sertx_word_hold.sv
module sertx_word_hold #(
  parameter int CH = 2,
  parameter int W  = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                valid,
  input  logic [CH-1:0][W-1:0] din,
  output logic [CH-1:0][W-1:0] q
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[c] <= '0;
      else if (load) q[c] <= valid ? din[c] : '0;
    end
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         emit,
  input  fmt_t                         fmt,
  input  logic [PH_W-1:0]              ph,
  input  logic [SLOT_IDX_W-1:0]        slot,
  input  logic [NUM_CH-1:0][SMP_W-1:0] words,
  output logic                         sclk_o,
  output logic                         lrclk_o,
  output logic                         fsync_o,
  output logic                         dout_o
);
  localparam int EXT_W = SLOT_IDX_W + 1;

  logic [EXT_W-1:0] h, first, upto, pos, bsel;
  logic [IDX_W-1:0] idx;
  logic             left, in_data, bit_d, fs_d, sclk_d;
  logic [SMP_W-1:0] word;

  always_comb begin
    left    = fmt.narrow ? ~slot[SLOT_IDX_W-2] : ~slot[SLOT_IDX_W-1];
    h       = fmt.narrow ? EXT_W'(slot[SLOT_IDX_W-3:0]) : EXT_W'(slot[SLOT_IDX_W-2:0]);
    first   = EXT_W'(fmt.first_slot);
    upto    = first + EXT_W'(fmt.wlen);
    in_data = (h >= first) && (h < upto);
    pos     = h - first;
    bsel    = fmt.msb_first ? (EXT_W'(fmt.wlen) - EXT_W'(1) - pos) : pos;
    idx     = IDX_W'(bsel + EXT_W'(SMP_W) - EXT_W'(fmt.wlen));
    word    = left ? words[0] : words[1];
    bit_d   = in_data ? word[idx] : 1'b0;
    fs_d    = fmt.fs_level ? in_data : (h == EXT_W'(fmt.mark_slot));
    sclk_d  = ph >= PH_W'(fmt.half_ph);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_o <= 1'b0; lrclk_o <= 1'b0; fsync_o <= 1'b0; dout_o <= 1'b0;
    end else if (!emit) begin
      sclk_o <= 1'b0; lrclk_o <= 1'b0; fsync_o <= 1'b0; dout_o <= 1'b0;
    end else begin
      sclk_o  <= sclk_d;
      lrclk_o <= left;
      fsync_o <= fs_d;
      dout_o  <= bit_d;
    end
  end
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import sertx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2:0]       mode,
  input  logic             cmode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] left_smp,
  input  logic [SMP_W-1:0] right_smp,
  output logic             sclk_o,
  output logic             lrclk_o,
  output logic             fsync_o,
  output logic             dout_o
);
  logic                         live, idle, start;
  fmt_t                         fmt_new, fmt_cur;
  logic [PH_W-1:0]              ph;
  logic [SLOT_IDX_W-1:0]        slot;
  logic [NUM_CH-1:0][SMP_W-1:0] din, words;

  assign live     = run && is_active_code(mode);
  assign fmt_new  = decode_fmt(mode, cmode);
  assign in_ready = start;
  assign din      = {right_smp, left_smp};

  sertx_frame_timer u_timer (
    .clk(clk), .rst_n(rst_n), .live(live), .fmt_in(fmt_new), .fmt_q(fmt_cur),
    .ph(ph), .slot(slot), .idle(idle), .start(start)
  );

  sertx_word_hold #(.CH(NUM_CH), .W(SMP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(start), .valid(in_valid), .din(din), .q(words)
  );

  sertx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .emit(live && !idle), .fmt(fmt_cur), .ph(ph), .slot(slot),
    .words(words), .sclk_o(sclk_o), .lrclk_o(lrclk_o), .fsync_o(fsync_o), .dout_o(dout_o)
  );
endmodule

// File: rtl/stereo_ser_tx_chk.sv
module stereo_ser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [2:0] mode,
  input logic       in_ready,
  input logic       sclk_o,
  input logic       lrclk_o,
  input logic       fsync_o,
  input logic       dout_o
);
  logic       live, seen;
  logic [1:0] age;
  logic [8:0] gap;

  assign live = run && (mode >= 3'b011);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0; seen <= 1'b0; gap <= '0;
    end else begin
      if (!live)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
      if (!live)          seen <= 1'b0;
      else if (in_ready)  seen <= 1'b1;
      if (in_ready)       gap <= '0;
      else if (gap != 9'h1FF) gap <= gap + 9'd1;
    end
  end

  assert_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (!sclk_o && !lrclk_o && !fsync_o && !dout_o));

  assert_no_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !in_ready);

  assert_edge_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$stable({lrclk_o, fsync_o, dout_o})) |-> $fell(sclk_o));

  assert_frame_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && seen && in_ready) |-> (gap == 9'd255 || gap == 9'd383));
endmodule

bind stereo_ser_tx stereo_ser_tx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .in_ready(in_ready),
  .sclk_o(sclk_o), .lrclk_o(lrclk_o), .fsync_o(fsync_o), .dout_o(dout_o)
);

// File: tb/test_stereo_ser_tx.sv
module test_stereo_ser_tx;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, run, cmode, in_valid, in_ready;
  logic [2:0]  mode;
  logic [17:0] lsmp, rsmp;
  logic        sclk_o, lrclk_o, fsync_o, dout_o;

  stereo_ser_tx i_stereo_ser_tx (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .cmode(cmode),
    .in_valid(in_valid), .in_ready(in_ready), .left_smp(lsmp), .right_smp(rsmp),
    .sclk_o(sclk_o), .lrclk_o(lrclk_o), .fsync_o(fsync_o), .dout_o(dout_o)
  );

  int    n_cmp = 0, n_bad = 0;
  int    fcnt;
  logic  bidle;
  int    bpos, bmode, bcm;
  logic [17:0] bL, bR;
  logic  e_sclk, e_lr, e_fs, e_do, e_idle;
  int    e_md;
  logic  chk_on = 1'b0;
  logic  ever_ran = 1'b0;
  string phase = "reset";

  function automatic logic [17:0] pat_l(int f);
    return 18'((f * 40503 + 777) ^ (f << 7));
  endfunction
  function automatic logic [17:0] pat_r(int f);
    return 18'((f * 91457 + 12345) ^ 32'h2AAAA);
  endfunction

  assign lsmp     = pat_l(fcnt);
  assign rsmp     = pat_r(fcnt);
  assign in_valid = (fcnt % 4) != 2;

  wire blive     = run && (mode >= 3'd3);
  wire exp_ready = blive && (bidle || bpos == ((bcm != 0) ? 384 : 256) - 1);

  // Arithmetic reference: {sclk, lrclk, fsync, dout} for a frame position.
  function automatic logic [3:0] calc(int pos, int md, int cm, logic [17:0] L, logic [17:0] R);
    int n, s, p, ph, sl, hh, h, w, st, k, b;
    logic left, sc, ind, msb, d, fs;
    logic [17:0] word;
    n = (cm != 0) ? 384 : 256;
    s = (md >= 6) ? 32 : 64;
    p = n / s; ph = pos % p; sl = pos / p; hh = s / 2; h = sl % hh;
    left = sl < hh;
    sc   = ph >= p / 2;
    w    = (md == 4 || md == 5) ? 18 : 16;
    st   = (md == 5) ? 14 : ((md >= 6) ? 0 : 1);
    msb  = !(md == 5 || md == 7);
    ind  = (h >= st) && (h < st + w);
    word = left ? L : R;
    d = 1'b0;
    if (ind) begin
      k = h - st;
      b = msb ? (w - 1 - k) : k;
      d = word[b + 18 - w];
    end
    fs = (md == 3) ? ind : (h == (st + hh - 1) % hh);
    return {sc, left, fs, d};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidle <= 1'b1; bpos <= 0; bmode <= 0; bcm <= 0; bL <= '0; bR <= '0; fcnt <= 0;
      {e_sclk, e_lr, e_fs, e_do} <= 4'b0; e_idle <= 1'b1; e_md <= 0;
    end else begin
      e_md <= bmode;
      if (!blive || bidle) begin
        {e_sclk, e_lr, e_fs, e_do} <= 4'b0; e_idle <= 1'b1;
      end else begin
        {e_sclk, e_lr, e_fs, e_do} <= calc(bpos, bmode, bcm, bL, bR); e_idle <= 1'b0;
      end
      if (!blive) begin
        bidle <= 1'b1; bpos <= 0;
      end else if (exp_ready) begin
        bidle <= 1'b0; bpos <= 0; bmode <= int'(mode); bcm <= int'(cmode);
        bL <= in_valid ? lsmp : 18'h0; bR <= in_valid ? rsmp : 18'h0;
        fcnt <= fcnt + 1;
      end else begin
        bpos <= bpos + 1;
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", req, phase, $time, act, exp);
    end
  endtask

  function automatic string mode_tag(int md);
    case (md)
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Per-cycle comparison; exact slot timing of every output also covers R4.
  always @(negedge clk) begin
    #2;
    if (chk_on && rst_n) begin
      if (e_idle) begin
        check(ever_ran ? "R12" : "R1", sclk_o,  1'b0);
        check(ever_ran ? "R12" : "R1", lrclk_o, 1'b0);
        check(ever_ran ? "R12" : "R1", fsync_o, 1'b0);
        check(ever_ran ? "R12" : "R1", dout_o,  1'b0);
      end else begin
        check("R3", sclk_o, e_sclk);
        check("R2", lrclk_o, e_lr);
        check(mode_tag(e_md), fsync_o, e_fs);
        check(e_do ? mode_tag(e_md) : "R9", dout_o, e_do);
      end
      check(ever_ran ? "R10" : "R1", in_ready, exp_ready);
    end
  end

  task automatic finish_run();
    chk_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; mode = 3'd0; cmode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; chk_on = 1'b1;
    phase = "R1 reset idle";
    repeat (20) @(negedge clk);
    ever_ran = 1'b1;

    // Sweep every active code and both frame lengths (R2, R3, R5-R10).
    for (int md = 3; md <= 7; md++) begin
      for (int cm = 0; cm <= 1; cm++) begin
        phase = $sformatf("sweep mode=%0d cmode=%0d", md, cm);
        run = 1'b0;
        repeat (4) @(negedge clk);
        mode = 3'(md); cmode = cm[0]; run = 1'b1;
        repeat (2 * ((cm != 0) ? 384 : 256) + 40) @(negedge clk);
      end
    end

    // Idle codes keep the pins low (R12).
    for (int md = 0; md <= 2; md++) begin
      phase = $sformatf("R12 idle code %0d", md);
      mode = 3'(md);
      repeat (30) @(negedge clk);
    end

    // Mid-frame change waits for the frame boundary (R11).
    phase = "R11 mid-frame change";
    mode = 3'd4; cmode = 1'b0;
    repeat (300) @(negedge clk);
    mode = 3'd7; cmode = 1'b1;
    repeat (500) @(negedge clk);

    // Change coinciding with the load cycle (R11, R10).
    phase = "R11 change in load cycle";
    do begin @(negedge clk); #1; end while (!exp_ready);
    mode = 3'd5; cmode = 1'b0;
    repeat (600) @(negedge clk);
    do begin @(negedge clk); #1; end while (!exp_ready);
    mode = 3'd3; cmode = 1'b1;
    repeat (500) @(negedge clk);

    // Run dropped part-way and restarted (R12).
    phase = "R12 run drop";
    run = 1'b0;
    repeat (10) @(negedge clk);
    run = 1'b1; mode = 3'd6; cmode = 1'b0;
    repeat (300) @(negedge clk);
    mode = 3'd1;
    repeat (10) @(negedge clk);

    finish_run();
  end
endmodule